// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames the architectural registers of an out-of-order core onto a larger pool of physical registers. When an instruction issues, each of its two source names is looked up in a speculative map. The destination name gets a physical register that nobody is using, taken from a free-list FIFO. The speculative map then points that name at the new register. Because every result gets its own register, write-after-write and write-after-read conflicts disappear. Holding the physical register file itself is outside this block, and so is scheduling.

A second map holds the committed state. When the retire logic commits an instruction, the block writes that instruction's physical register into the committed map. The register that the committed map held for the same name before is pushed back onto the free list. When a misprediction is signalled, the block takes one cycle to throw away every uncommitted mapping. It copies the committed map into the speculative map and rebuilds the free list from the physical registers the committed map does not use. The free list is rebuilt in ascending order.

A two-state controller gates issue. In state FREE the free list has at least one entry and issue is accepted. Transition FREE→DRY happens when the last free entry is taken and no entry comes back in the same cycle. In state DRY issue stalls. Transition DRY→FREE happens on any commit push or on a recovery.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register n maps to physical register n in both maps for n = 0..7. Issue is ready, and the free list hands out physical registers 8, 9, ..., 15 in that order.
- R2: In the same cycle, `iss_phys_a` and `iss_phys_b` show the speculative mapping of `iss_src_a` and `iss_src_b`. This holds whether or not an issue takes place.
- R3: An issue takes place when `iss_valid` and `iss_ready` are both 1 and `recover` is 0. It takes the head of the free list, which is shown on `iss_phys_dst`, and the speculative entry for `iss_dst` holds that register from the next cycle on. The register taken is never one the speculative map currently holds.
- R4: When a source names the same architectural register as the destination in the same issue, the source gets the mapping that was in place before that issue.
- R5: `iss_ready` is 0 exactly while the free list is empty. While it is 0, `iss_valid` has no effect on either map. A commit in a DRY cycle raises `iss_ready` in the next cycle, not in the same cycle.
- R6: A commit writes `cmt_phys` into the committed entry for `cmt_arch`. The physical register that entry held before is pushed onto the free-list tail and comes out after the entries already queued.
- R7: On `recover`, the speculative map equals the committed map from the next cycle on. An issue presented in the recover cycle is dropped.
- R8: After `recover`, the free list holds the 8 physical registers that the committed map does not use, in ascending numeric order, and issue is ready.
- R9: A commit presented in the same cycle as `recover` is applied to the committed map before that map is copied and the free list is rebuilt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for renaming |
| iss_dst | input | 3 | Architectural destination name |
| iss_src_a | input | 3 | First architectural source name |
| iss_src_b | input | 3 | Second architectural source name |
| iss_ready | output | 1 | Free list not empty; issue accepted |
| iss_phys_a | output | 4 | Physical register for the first source |
| iss_phys_b | output | 4 | Physical register for the second source |
| iss_phys_dst | output | 4 | Physical register given to the destination |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_arch | input | 3 | Architectural name of the committing result |
| cmt_phys | input | 4 | Physical register holding that result |
| recover | input | 1 | Misprediction: discard all uncommitted mappings |

## Verification
The main function is tried with four kinds of issue streams. One is a chain where each source reads the previous destination, which separates using the new mapping from using the stale one. Another has source equal to destination in the same issue, which shows that the old mapping is used. A third runs issue until the free list is empty and then keeps `iss_valid` high, which shows that a stalled request leaves the map untouched. The last is a stream of commits that refill the free list, which separates FIFO order from any other order. Recovery is tried with a commit and an issue in the same cycle, so the result shows whether the commit was applied first and the issue dropped. The order of the first registers handed out afterwards tells a sorted rebuild apart from a replay of the old queue.

// File: rtl/rename_pkg.sv
package rename_pkg;

    // issue gate: FREE while the free list holds an entry, DRY when it is empty
    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_DRY  = 1'b1
    } rn_state_e;

endpackage

// File: rtl/rename_map.sv
module rename_map #(
    parameter int ARCH = 8,
    parameter int PHYS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spec_we,
    input  logic [$clog2(ARCH)-1:0]       spec_dst,
    input  logic [$clog2(PHYS)-1:0]       spec_phys,
    input  logic                          cmt_we,
    input  logic [$clog2(ARCH)-1:0]       cmt_arch,
    input  logic [$clog2(PHYS)-1:0]       cmt_phys,
    input  logic                          recover,
    input  logic [$clog2(ARCH)-1:0]       rd_a,
    input  logic [$clog2(ARCH)-1:0]       rd_b,
    output logic [$clog2(PHYS)-1:0]       rd_pa,
    output logic [$clog2(PHYS)-1:0]       rd_pb,
    output logic [$clog2(PHYS)-1:0]       cmt_prev,
    output logic [ARCH*$clog2(PHYS)-1:0]  spec_flat,
    output logic [ARCH*$clog2(PHYS)-1:0]  cmt_next_flat
);

    localparam int PW = $clog2(PHYS);

    logic [PW-1:0] spec_q [ARCH];
    logic [PW-1:0] cmt_q  [ARCH];
    logic [PW-1:0] cmt_d  [ARCH];
    logic [ARCH*PW-1:0] cmt_flat;

    // committed map as it stands after this cycle's commit
    always_comb begin
        for (int i = 0; i < ARCH; i++) begin
            cmt_d[i] = cmt_q[i];
        end
        if (cmt_we) begin
            cmt_d[cmt_arch] = cmt_phys;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH; i++) begin
                spec_q[i] <= PW'(i);
                cmt_q[i]  <= PW'(i);
            end
        end else begin
            for (int i = 0; i < ARCH; i++) begin
                cmt_q[i] <= cmt_d[i];
            end
            if (recover) begin
                for (int i = 0; i < ARCH; i++) begin
                    spec_q[i] <= cmt_d[i];
                end
            end else if (spec_we) begin
                spec_q[spec_dst] <= spec_phys;
            end
        end
    end

    // reads see the map before this cycle's write
    assign rd_pa    = spec_q[rd_a];
    assign rd_pb    = spec_q[rd_b];
    assign cmt_prev = cmt_q[cmt_arch];

    for (genvar g = 0; g < ARCH; g++) begin : g_flat
        assign spec_flat[g*PW +: PW]     = spec_q[g];
        assign cmt_flat[g*PW +: PW]      = cmt_q[g];
        assign cmt_next_flat[g*PW +: PW] = cmt_d[g];
    end

    AST_RECOVER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (spec_flat == cmt_flat)); // R7

    AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_we && !recover) |=> $stable(spec_flat)); // R5

endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
    parameter int ARCH = 8,
    parameter int PHYS = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               pop,
    input  logic                               push,
    input  logic [$clog2(PHYS)-1:0]            push_phys,
    input  logic                               rebuild,
    input  logic [ARCH*$clog2(PHYS)-1:0]       map_flat,
    output logic [$clog2(PHYS)-1:0]            head_phys,
    output logic [$clog2(PHYS-ARCH+1)-1:0]     count
);

    localparam int PW    = $clog2(PHYS);
    localparam int DEPTH = PHYS - ARCH;
    localparam int DW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [PW-1:0] mem_q [DEPTH];
    logic [PW-1:0] reb   [DEPTH];
    logic [DW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic [PHYS-1:0] used;

    function automatic logic [DW-1:0] step_ptr(input logic [DW-1:0] p);
        return (p == DW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // unused physical registers of the given map, lowest number first
    always_comb begin
        int idx;
        used = '0;
        for (int a = 0; a < ARCH; a++) begin
            used[map_flat[a*PW +: PW]] = 1'b1;
        end
        for (int k = 0; k < DEPTH; k++) begin
            reb[k] = '0;
        end
        idx = 0;
        for (int p = 0; p < PHYS; p++) begin
            if (!used[p]) begin
                if (idx < DEPTH) begin
                    reb[idx] = PW'(p);
                end
                idx = idx + 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= PW'(ARCH + i);
            end
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= CW'(DEPTH);
        end else if (rebuild) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= reb[i];
            end
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= CW'(DEPTH);
        end else begin
            if (push) begin
                mem_q[tail_q] <= push_phys;
                tail_q        <= step_ptr(tail_q);
            end
            if (pop) begin
                head_q <= step_ptr(head_q);
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_phys = mem_q[head_q];
    assign count     = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !rebuild) |-> (cnt_q < CW'(DEPTH))); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0)); // R5

    AST_REBUILD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rebuild |=> (cnt_q == CW'(DEPTH))); // R8

endmodule

// File: rtl/rename_ctrl.sv
module rename_ctrl
    import rename_pkg::*;
#(
    parameter int ARCH = 8,
    parameter int PHYS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           iss_valid,
    input  logic                           cmt_valid,
    input  logic                           recover,
    input  logic [$clog2(PHYS-ARCH+1)-1:0] fl_count,
    output logic                           iss_ready,
    output logic                           pop,
    output logic                           push,
    output logic                           rebuild
);

    localparam int CW = $clog2(PHYS - ARCH + 1);

    rn_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (!recover && pop && !push && fl_count == CW'(1)) begin
                    state_d = ST_DRY;
                end
            end
            ST_DRY: begin
                if (recover || push) begin
                    state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        iss_ready = (state_q == ST_FREE);
        pop       = iss_valid && iss_ready && !recover;
        push      = cmt_valid && !recover;
        rebuild   = recover;
    end

    AST_READY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready == (fl_count != '0)); // R5

    AST_DRY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRY && push) |=> iss_ready); // R5

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int ARCH = 8,
    parameter int PHYS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [$clog2(ARCH)-1:0] iss_dst,
    input  logic [$clog2(ARCH)-1:0] iss_src_a,
    input  logic [$clog2(ARCH)-1:0] iss_src_b,
    output logic                    iss_ready,
    output logic [$clog2(PHYS)-1:0] iss_phys_a,
    output logic [$clog2(PHYS)-1:0] iss_phys_b,
    output logic [$clog2(PHYS)-1:0] iss_phys_dst,
    input  logic                    cmt_valid,
    input  logic [$clog2(ARCH)-1:0] cmt_arch,
    input  logic [$clog2(PHYS)-1:0] cmt_phys,
    input  logic                    recover
);

    localparam int PW = $clog2(PHYS);
    localparam int CW = $clog2(PHYS - ARCH + 1);

    logic              pop, push, rebuild;
    logic [CW-1:0]     fl_count;
    logic [PW-1:0]     head_phys, cmt_prev;
    logic [ARCH*PW-1:0] spec_flat, cmt_next_flat;
    logic              collide;

    rename_ctrl #(.ARCH(ARCH), .PHYS(PHYS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .cmt_valid(cmt_valid),
        .recover(recover), .fl_count(fl_count), .iss_ready(iss_ready),
        .pop(pop), .push(push), .rebuild(rebuild)
    );

    rename_map #(.ARCH(ARCH), .PHYS(PHYS)) u_map (
        .clk(clk), .rst_n(rst_n), .spec_we(pop), .spec_dst(iss_dst),
        .spec_phys(head_phys), .cmt_we(cmt_valid), .cmt_arch(cmt_arch),
        .cmt_phys(cmt_phys), .recover(recover), .rd_a(iss_src_a), .rd_b(iss_src_b),
        .rd_pa(iss_phys_a), .rd_pb(iss_phys_b), .cmt_prev(cmt_prev),
        .spec_flat(spec_flat), .cmt_next_flat(cmt_next_flat)
    );

    rename_freelist #(.ARCH(ARCH), .PHYS(PHYS)) u_free (
        .clk(clk), .rst_n(rst_n), .pop(pop), .push(push), .push_phys(cmt_prev),
        .rebuild(rebuild), .map_flat(cmt_next_flat), .head_phys(head_phys),
        .count(fl_count)
    );

    assign iss_phys_dst = head_phys;

    always_comb begin
        collide = 1'b0;
        for (int a = 0; a < ARCH; a++) begin
            if (spec_flat[a*PW +: PW] == head_phys) begin
                collide = 1'b1;
            end
        end
    end

    AST_FRESH_DST: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !collide); // R3

endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic       iss_ready;
    logic [3:0] iss_phys_a, iss_phys_b, iss_phys_dst;
    logic       cmt_valid = 1'b0;
    logic [2:0] cmt_arch = '0;
    logic [3:0] cmt_phys = '0;
    logic       recover = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_spec [8];
    int m_cmt  [8];
    int m_fl   [8];
    int m_hd, m_tl, m_cnt;

    always #5 clk = ~clk;

    rename_unit u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_ready(iss_ready),
        .iss_phys_a(iss_phys_a), .iss_phys_b(iss_phys_b), .iss_phys_dst(iss_phys_dst),
        .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_phys(cmt_phys),
        .recover(recover)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, compare outputs, update the model
    task automatic step(input bit iv, input int dst, input int sa, input int sb,
                        input bit cv, input int ca, input int cp, input bit rc);
        bit rdy;
        int used [16];
        @(negedge clk);
        iss_valid = iv; iss_dst = 3'(dst); iss_src_a = 3'(sa); iss_src_b = 3'(sb);
        cmt_valid = cv; cmt_arch = 3'(ca); cmt_phys = 4'(cp); recover = rc;
        #1;
        rdy = (m_cnt != 0);
        chk("R2 src a", int'(iss_phys_a), m_spec[sa]);
        chk("R2 src b", int'(iss_phys_b), m_spec[sb]);
        chk("R5 ready", int'(iss_ready), int'(rdy));
        if (rdy) chk("R3 dst", int'(iss_phys_dst), m_fl[m_hd]);
        if (rc) begin
            if (cv) m_cmt[ca] = cp;
            for (int i = 0; i < 16; i++) used[i] = 0;
            for (int a = 0; a < 8; a++) begin
                m_spec[a] = m_cmt[a];
                used[m_cmt[a]] = 1;
            end
            m_cnt = 0;
            for (int p = 0; p < 16; p++) begin
                if (used[p] == 0 && m_cnt < 8) begin
                    m_fl[m_cnt] = p;
                    m_cnt++;
                end
            end
            m_hd = 0; m_tl = 0;
        end else begin
            if (iv && rdy) begin
                m_spec[dst] = m_fl[m_hd];
                m_hd = (m_hd + 1) % 8;
                m_cnt--;
            end
            if (cv) begin
                m_fl[m_tl] = m_cmt[ca];
                m_tl = (m_tl + 1) % 8;
                m_cnt++;
                m_cmt[ca] = cp;
            end
        end
        @(posedge clk);
    endtask

    task automatic look(input int sa, input int sb);
        @(negedge clk);
        iss_valid = 0; cmt_valid = 0; recover = 0;
        iss_src_a = 3'(sa); iss_src_b = 3'(sb);
        #1;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a += 2) begin
            look(a, a + 1);
            chk("R1 map a", int'(iss_phys_a), a);
            chk("R1 map b", int'(iss_phys_b), a + 1);
        end
        chk("R1 ready", int'(iss_ready), 1);
        chk("R1 first free", int'(iss_phys_dst), 8);
    endtask

    task automatic t_chain;
        look(3, 3);
        chk("R4 same name before issue", int'(iss_phys_a), 3);
        step(1, 3, 3, 1, 0, 0, 0, 0);   // r3 -> p8, source r3 sees p3
        look(3, 5);
        chk("R3 new mapping", int'(iss_phys_a), 8);
        chk("R3 next free", int'(iss_phys_dst), 9);
        step(1, 5, 3, 5, 0, 0, 0, 0);   // r5 -> p9
        look(5, 3);
        chk("R2 chained read", int'(iss_phys_a), 9);
    endtask

    task automatic t_exhaust;
        step(1, 0, 0, 1, 0, 0, 0, 0);   // p10
        step(1, 1, 1, 2, 0, 0, 0, 0);   // p11
        step(1, 2, 2, 4, 0, 0, 0, 0);   // p12
        step(1, 4, 4, 6, 0, 0, 0, 0);   // p13
        step(1, 6, 6, 7, 0, 0, 0, 0);   // p14
        step(1, 7, 7, 0, 0, 0, 0, 0);   // p15
        look(2, 7);
        chk("R5 empty stalls", int'(iss_ready), 0);
        step(1, 2, 2, 2, 0, 0, 0, 0);   // refused
        look(2, 7);
        chk("R5 stalled issue ignored", int'(iss_phys_a), 12);
        chk("R5 still dry", int'(iss_ready), 0);
    endtask

    task automatic t_commit;
        step(0, 0, 3, 5, 1, 3, 8, 0);   // frees p3
        look(3, 5);
        chk("R6 ready after commit", int'(iss_ready), 1);
        chk("R6 freed register", int'(iss_phys_dst), 3);
        step(0, 0, 3, 5, 1, 5, 9, 0);   // frees p5, queued behind p3
        step(1, 1, 1, 1, 0, 0, 0, 0);   // r1 -> p3
        look(1, 0);
        chk("R6 fifo order", int'(iss_phys_a), 3);
        chk("R6 second freed", int'(iss_phys_dst), 5);
    endtask

    task automatic t_recover;
        // commit r0=p10 with recover; the r4 issue must be dropped
        step(1, 4, 0, 1, 1, 0, 10, 1);
        look(0, 1);
        chk("R9 commit before restore", int'(iss_phys_a), 10);
        chk("R7 speculative r1 dropped", int'(iss_phys_b), 1);
        chk("R8 ready", int'(iss_ready), 1);
        chk("R8 lowest unused", int'(iss_phys_dst), 0);
        look(4, 3);
        chk("R7 issue in recover cycle dropped", int'(iss_phys_a), 4);
        chk("R7 committed r3", int'(iss_phys_b), 8);
        step(1, 6, 6, 6, 0, 0, 0, 0);   // p0
        look(6, 6);
        chk("R8 second unused", int'(iss_phys_dst), 3);
        step(1, 7, 6, 7, 0, 0, 0, 0);   // p3
        look(7, 6);
        chk("R8 third unused", int'(iss_phys_dst), 5);
        chk("R3 after recovery", int'(iss_phys_a), 3);
    endtask

    initial begin
        for (int a = 0; a < 8; a++) begin
            m_spec[a] = a; m_cmt[a] = a; m_fl[a] = 8 + a;
        end
        m_hd = 0; m_tl = 0; m_cnt = 8;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chain();
        t_exhaust();
        t_commit();
        t_recover();
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule